// File: doc/BRIEF.md
# Free-Running 64-Bit Counter with Tear-Free Split Read

This block keeps a 64-bit count that advances by one at a fixed tick rate, 2 MHz by default. The tick rate is derived from the core clock by an integer prescaler. The count has no reset other than the block reset and cannot be written. When it passes all ones it wraps to zero and raises no flag.

Software sees the count through two read-only 32-bit words on a simple read port. Reading the low word at byte offset 0x024 returns the lower 32 bits. The same read copies the upper bits into a snapshot register. Reading the high word at byte offset 0x028 returns that snapshot, not the live upper bits. A low-then-high read pair therefore always assembles one coherent 64-bit value, even when a carry ripples into the upper half between the two accesses.

Read data appears on the cycle after the request and holds until the next request.

Top module: `split_read_counter`

## Requirements
- R1: After reset, `rd_data` is 0, the high-word snapshot is 0 (a high-word read before any low-word read returns 0), and the count equals the parameter `START`.
- R2: The count increases by exactly one every DIV core clocks, where DIV = CLK_HZ / TICK_HZ. After k clock edges out of reset the count is START + floor(k / DIV).
- R3: The count wraps from all ones to zero, modulo 2^CNT_W, with no other effect.
- R4: A read with `rd_en`=1 and `rd_addr`=0x24 puts bits [31:0] of the count, as sampled at that clock edge, on `rd_data` one cycle later. The same edge copies bits [63:32] into the snapshot.
- R5: A read with `rd_addr`=0x28 puts the snapshot on `rd_data` one cycle later. The assembled pair {high, low} equals the count at the low-word read, even across a carry out of bit 31, so successive pairs never decrease.
- R6: The snapshot changes only on a low-word read, so repeated high-word reads return the same value.
- R7: A read of any other address returns 0 and leaves the snapshot unchanged. While `rd_en`=0, `rd_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request, one access per cycle |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | BUS_W | Read data, valid the cycle after the request |

## Verification
The bench starts one instance just below a carry out of bit 31 and waits until the count is 0x00000000_FFFFFFFF. It then reads the low word and, after the carry has happened, the high word; a design returning live upper bits would give a high word of 1 and an assembled value that jumps ahead by 2^32. A second instance starts a few ticks below all ones to show the wrap to zero. A sweep of read pairs with varying gaps checks each assembled value against START + floor(k/DIV) and checks that the values never decrease; a prescaler off by one would drift from this formula within a few pairs. Repeated high-word reads, unmapped addresses and idle cycles are interleaved; a snapshot that updated on the wrong access would change the high word they return.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // Decoded kind of read access presented on the bus this cycle.
    typedef enum logic [1:0] {
        SEL_IDLE  = 2'd0,
        SEL_LO    = 2'd1,
        SEL_HI    = 2'd2,
        SEL_OTHER = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/ctr_tick_gen.sv
module ctr_tick_gen #(
    parameter int unsigned DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == LAST) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.phase == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // R2: with a divider above one, two ticks are never adjacent
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ctr_count_core.sv
module ctr_count_core #(
    parameter int unsigned    CNT_W = 64,
    parameter logic [CNT_W-1:0] START = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.value = st_q.value + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.value <= START;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.value;

    // R2: a tick advances the count by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + CNT_W'(1)));
    // R2: without a tick the count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
    // R3: all ones rolls over to zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count)) |=> (count == '0));

endmodule

// File: rtl/ctr_read_decode.sv
module ctr_read_decode
    import ctr_pkg::*;
#(
    parameter int unsigned        ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]  LO_ADDR = 8'h24,
    parameter logic [ADDR_W-1:0]  HI_ADDR = 8'h28
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output rd_sel_e           sel
);
    always_comb begin
        if (!rd_en) begin
            sel = SEL_IDLE;
        end else if (rd_addr == LO_ADDR) begin
            sel = SEL_LO;
        end else if (rd_addr == HI_ADDR) begin
            sel = SEL_HI;
        end else begin
            sel = SEL_OTHER;
        end
    end

    // R7: only one kind of access can be chosen, and an idle bus chooses none
    always_comb begin
        if (!rd_en) begin
            a_r7_idle_decode: assert (sel == SEL_IDLE);
        end
    end

endmodule

// File: rtl/ctr_snap_port.sv
module ctr_snap_port
    import ctr_pkg::*;
#(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rd_sel_e          sel,
    input  logic [CNT_W-1:0] count,
    output logic [BUS_W-1:0] rd_data
);
    localparam int unsigned HI_W = CNT_W - BUS_W;

    typedef struct packed {
        logic [HI_W-1:0]  snap_hi;
        logic [BUS_W-1:0] data;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (sel)
            SEL_LO: begin
                st_d.data    = count[BUS_W-1:0];
                st_d.snap_hi = count[CNT_W-1:BUS_W];
            end
            SEL_HI: begin
                st_d.data = BUS_W'(st_q.snap_hi);
            end
            SEL_OTHER: begin
                st_d.data = '0;
            end
            default: begin
                st_d.data = st_q.data;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data;

    // R4: a low-word read captures the upper half of the count seen at that edge
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_LO) |=> (st_q.snap_hi == $past(count[CNT_W-1:BUS_W])));
    // R4: low-word data is the lower half of the count seen at the request edge
    a_r4_low_data: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_LO) |=> (rd_data == $past(count[BUS_W-1:0])));
    // R6: only a low-word read may move the snapshot
    a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_LO) |=> $stable(st_q.snap_hi));
    // R7: unmapped reads return zero
    a_r7_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_OTHER) |=> (rd_data == '0));
    // R7: an idle bus keeps the read data
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_IDLE) |=> $stable(rd_data));

endmodule

// File: rtl/split_read_counter.sv
module split_read_counter
    import ctr_pkg::*;
#(
    parameter int unsigned       CNT_W   = 64,
    parameter int unsigned       BUS_W   = 32,
    parameter int unsigned       ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h24,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h28,
    parameter int unsigned       CLK_HZ  = 100_000_000,
    parameter int unsigned       TICK_HZ = 2_000_000,
    parameter logic [CNT_W-1:0]  START   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data
);
    localparam int unsigned DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

    logic             tick;
    logic [CNT_W-1:0] count;
    rd_sel_e          sel;

    ctr_tick_gen #(
        .DIV (DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ctr_count_core #(
        .CNT_W (CNT_W),
        .START (START)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (count)
    );

    ctr_read_decode #(
        .ADDR_W  (ADDR_W),
        .LO_ADDR (LO_ADDR),
        .HI_ADDR (HI_ADDR)
    ) u_decode (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .sel     (sel)
    );

    ctr_snap_port #(
        .CNT_W (CNT_W),
        .BUS_W (BUS_W)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .count   (count),
        .rd_data (rd_data)
    );

    // R1: the first cycle out of reset shows the start value and empty read data
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (count == START && rd_data == '0));

endmodule

// File: tb/sim_split_read_counter.sv
module sim_split_read_counter;

    localparam int unsigned CLK_HZ  = 6_000_000;
    localparam int unsigned TICK_HZ = 2_000_000;
    localparam longint unsigned DIV = CLK_HZ / TICK_HZ;
    localparam logic [63:0] START0  = 64'h0000_0000_FFFF_FFF0;
    localparam logic [63:0] START1  = 64'hFFFF_FFFF_FFFF_FFF8;
    localparam logic [7:0]  A_LO    = 8'h24;
    localparam logic [7:0]  A_HI    = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = 8'h00;
    logic [31:0] rd_data0, rd_data1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    longint unsigned edges = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) edges <= edges + 1;
        else       edges <= 0;
    end

    split_read_counter #(
        .CLK_HZ (CLK_HZ), .TICK_HZ (TICK_HZ), .START (START0)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data0)
    );

    split_read_counter #(
        .CLK_HZ (CLK_HZ), .TICK_HZ (TICK_HZ), .START (START1)
    ) u1 (
        .clk (clk), .rst_n (rst_n), .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data1)
    );

    function automatic logic [63:0] expect_cnt(logic [63:0] start, longint unsigned k);
        return start + 64'(k / DIV);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the data is registered.
    task automatic bus_read(input logic [7:0] a, output longint unsigned k,
                            output logic [31:0] d0, output logic [31:0] d1);
        rd_en   = 1'b1;
        rd_addr = a;
        k = edges;
        @(posedge clk);
        @(negedge clk);
        rd_en   = 1'b0;
        rd_addr = 8'h00;
        d0 = rd_data0;
        d1 = rd_data1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        longint unsigned k, kh, k2;
        logic [31:0] lo0, lo1, hi0, hi1, h2a, h2b;
        logic [63:0] prev;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 rd_data after reset", 64'(rd_data0), 64'h0);
        bus_read(A_HI, kh, hi0, hi1);
        chk("R1 snapshot empty before low read", 64'(hi0), 64'h0);
        bus_read(A_LO, k, lo0, lo1);
        chk("R1 R4 first low word", 64'(lo0), 64'(expect_cnt(START0, k) & 64'hFFFF_FFFF));

        // R5: force a pair straddling the carry out of bit 31
        while (expect_cnt(START0, edges) != 64'h0000_0000_FFFF_FFFF) @(negedge clk);
        bus_read(A_LO, k, lo0, lo1);
        chk("R5 low word at carry edge", 64'(lo0), 64'hFFFF_FFFF);
        idle(6);
        bus_read(A_HI, kh, hi0, hi1);
        chk("R5 high word not torn by carry", 64'(hi0), 64'h0);
        chk("R2 carry did happen meanwhile", expect_cnt(START0, kh) >> 32, 64'h1);
        // R3: the second instance has wrapped through zero by now
        chk("R3 wrapped value", {hi1, lo1}, expect_cnt(START1, k));
        chk("R3 wrapped high is zero", 64'(hi1), 64'h0);
        prev = {hi0, lo0};

        // R5 R6 sweep of pairs with varying gaps
        for (int i = 0; i < 60; i++) begin
            logic [63:0] asm0, asm1;
            bus_read(A_LO, k, lo0, lo1);
            idle(i % 7);
            bus_read(A_HI, kh, hi0, hi1);
            asm0 = {hi0, lo0};
            asm1 = {hi1, lo1};
            chk("R5 assembled pair u0", asm0, expect_cnt(START0, k));
            chk("R3 assembled pair u1", asm1, expect_cnt(START1, k));
            chk("R5 monotonic", 64'(asm0 >= prev), 64'h1);
            prev = asm0;
            if (i % 5 == 0) begin
                bus_read(A_HI, kh, h2a, h2b);
                chk("R6 repeated high read", 64'(h2a), 64'(hi0));
            end
        end

        // R2: rate between two low reads
        bus_read(A_LO, k, lo0, lo1);
        idle(30);
        bus_read(A_LO, k2, h2a, h2b);
        chk("R2 tick count between reads", 64'(h2a - lo0), 64'((k2 / DIV) - (k / DIV)));

        // R7: unmapped addresses and idle hold
        bus_read(A_HI, kh, hi0, hi1);
        bus_read(8'h00, kh, h2a, h2b);
        chk("R7 unmapped 0x00 reads zero", 64'(h2a), 64'h0);
        bus_read(8'h2C, kh, h2a, h2b);
        chk("R7 unmapped 0x2c reads zero", 64'(h2a), 64'h0);
        bus_read(A_HI, kh, h2a, h2b);
        chk("R7 snapshot kept after unmapped", 64'(h2a), 64'(hi0));
        bus_read(A_LO, k, lo0, lo1);
        idle(5);
        chk("R7 idle holds rd_data", 64'(rd_data0), 64'(lo0));
        chk("R4 low word value", 64'(lo0), 64'(expect_cnt(START0, k) & 64'hFFFF_FFFF));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule